// File: doc/BRIEF.md
# Configurable Link Crossbar with Command Processor

This block routes 32 single-bit serial link inputs to 32 link outputs. Each output has its own 32-to-1 selector. A per-output routing entry holds a 5-bit source number and a connected flag, and it drives that selector. Every input passes through a synchroniser on the fast internal clock. Each output is registered again before it leaves the block. The switch therefore regenerates each routed signal instead of passing it through combinationally, and a disconnected output is forced low.

A configuration link receiver supplies a byte stream with valid/ready that programs the routing entries. Each command is one, two or three bytes long, and its first byte is an opcode. New connections are first written into a staging table. A commit command then copies the staging table into the live table that drives the selectors. Disconnects take effect at once in both tables. An enquiry command returns one response byte on a valid/ready output stream.

Top module: `xbar_switch`

## Requirements
- R1: After synchronous reset every output is low, every routing entry reads back as disconnected with source 0, no response is pending and `cmd_ready` is high.
- R2: A live connected output `o` with source `s` drives `link_in[s]` three clock edges later: two synchroniser stages and one output register.
- R3: Opcode 0 with operands (source, output) writes only the staging entry of that output (connected, that source). The live table and `link_out` do not change.
- R4: Opcode 1 with operands (A, B) stages source A for output B and source B for output A, both connected.
- R5: Opcode 3 (single byte) copies the whole staging table into the live table. The accepted commit byte affects `link_out` at the second clock edge after its accepting edge.
- R6: Opcode 2 with an output number returns one response byte from the live table. Bit 7 is the connected flag, bits 6..5 are zero and bits 4..0 are the source.
- R7: Opcode 4 (single byte) clears both tables immediately: every output is disconnected with source 0, and all outputs go low.
- R8: Opcode 5 with an output number clears the connected flag of that output in both tables at once and keeps its source field. The output goes low.
- R9: Opcode 6 with operands (A, B) disconnects outputs A and B in both tables in the same way.
- R10: A disconnected output stays low whatever its selected input does.
- R11: An opcode byte of 7 or more is ignored. An operand byte of 32 or more abandons the command without effect and without a response. Either way the next byte is taken as an opcode.
- R12: While a response is pending, or an enquiry is decoded but not yet answered, `cmd_ready` is low. A response not accepted by `rsp_ready` keeps `rsp_valid` and `rsp_byte` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte is offered |
| cmd_ready | output | 1 | Command byte is accepted on this edge |
| cmd_byte | input | 8 | Command or operand byte |
| rsp_valid | output | 1 | Enquiry response is available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_byte | output | 8 | Enquiry response byte |
| link_in | input | 32 | Raw link input bits, asynchronous |
| link_out | output | 32 | Regenerated, registered link output bits |

## Verification
The bench holds fixed input patterns to show that staged routes stay invisible until a commit. A design that drives the live table directly from opcode 0 would light the output early. It stages a route, removes it before the commit, and checks that the commit does not bring it back and that the source field survives in the enquiry byte. It sends opcodes of 7 or more and out-of-range operands, then checks that no response appears and that a following valid command still parses. A parser that stays in an operand state would misread that command. A random stream of commands against a cycle-exact behavioural model catches any latency slip in the synchroniser or the commit path. Stalled responses check that the response holds and that command intake blocks.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    parameter int unsigned N_LINKS = 32;
    parameter int unsigned BYTE_W  = 8;
    localparam int unsigned SEL_W  = $clog2(N_LINKS);

    localparam logic [BYTE_W-1:0] OP_LIMIT  = BYTE_W'(7);
    localparam logic [BYTE_W-1:0] ARG_LIMIT = BYTE_W'(N_LINKS);

    typedef enum logic [2:0] {
        OP_ROUTE     = 3'd0,
        OP_PAIR      = 3'd1,
        OP_QUERY     = 3'd2,
        OP_COMMIT    = 3'd3,
        OP_CLEAR     = 3'd4,
        OP_DROP      = 3'd5,
        OP_DROP_PAIR = 3'd6
    } op_e;

    typedef struct packed {
        logic             on;
        logic [SEL_W-1:0] src;
    } route_t;

    typedef struct packed {
        logic             vld;
        op_e              op;
        logic [SEL_W-1:0] a;
        logic [SEL_W-1:0] b;
    } cmd_t;

    function automatic logic [1:0] op_args(op_e op);
        case (op)
            OP_ROUTE, OP_PAIR, OP_DROP_PAIR: return 2'd2;
            OP_QUERY, OP_DROP:               return 2'd1;
            default:                         return 2'd0;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pack_resp(route_t r);
        return {r.on, {(BYTE_W-1-SEL_W){1'b0}}, r.src};
    endfunction

endpackage

// File: rtl/xbar_cmd_parser.sv
module xbar_cmd_parser
    import xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              rsp_pending,
    output cmd_t              cmd
);

    typedef enum logic [1:0] {P_OP, P_ARG1, P_ARG2} pstate_e;

    pstate_e          st_q, st_d;
    op_e              op_q, op_d;
    logic [SEL_W-1:0] a_q, a_d;
    cmd_t             cmd_q, cmd_d;
    logic             take, op_ok, arg_ok;
    op_e              new_op;
    logic [SEL_W-1:0] arg;

    assign in_ready = !rsp_pending && !(cmd_q.vld && cmd_q.op == OP_QUERY);
    assign take     = in_valid && in_ready;
    assign op_ok    = in_byte < OP_LIMIT;
    assign arg_ok   = in_byte < ARG_LIMIT;
    assign new_op   = op_e'(in_byte[2:0]);
    assign arg      = in_byte[SEL_W-1:0];

    always_comb begin
        st_d  = st_q;
        op_d  = op_q;
        a_d   = a_q;
        cmd_d = '0;
        if (take) begin
            case (st_q)
                P_OP: begin
                    if (op_ok) begin
                        op_d = new_op;
                        if (op_args(new_op) == 2'd0) begin
                            cmd_d.vld = 1'b1;
                            cmd_d.op  = new_op;
                        end else begin
                            st_d = P_ARG1;
                        end
                    end
                end
                P_ARG1: begin
                    if (!arg_ok) begin
                        st_d = P_OP;
                    end else if (op_args(op_q) == 2'd1) begin
                        st_d      = P_OP;
                        cmd_d.vld = 1'b1;
                        cmd_d.op  = op_q;
                        cmd_d.a   = arg;
                    end else begin
                        a_d  = arg;
                        st_d = P_ARG2;
                    end
                end
                default: begin
                    st_d = P_OP;
                    if (arg_ok) begin
                        cmd_d.vld = 1'b1;
                        cmd_d.op  = op_q;
                        cmd_d.a   = a_q;
                        cmd_d.b   = arg;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= P_OP;
            op_q  <= OP_ROUTE;
            a_q   <= '0;
            cmd_q <= '0;
        end else begin
            st_q  <= st_d;
            op_q  <= op_d;
            a_q   <= a_d;
            cmd_q <= cmd_d;
        end
    end

    assign cmd = cmd_q;

    AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_pending |-> !in_ready); // R12

    AST_BAD_OPCODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (take && st_q == P_OP && !op_ok) |=> (!cmd_q.vld && st_q == P_OP)); // R11

    AST_BAD_ARG_ABANDONS: assert property (@(posedge clk) disable iff (rst)
        (take && st_q != P_OP && !arg_ok) |=> (!cmd_q.vld && st_q == P_OP)); // R11

endmodule

// File: rtl/xbar_route_table.sv
module xbar_route_table
    import xbar_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  cmd_t                      cmd,
    input  logic                      rsp_ready,
    output logic                      rsp_valid,
    output logic [BYTE_W-1:0]         rsp_byte,
    output route_t [N_LINKS-1:0]      live
);

    route_t [N_LINKS-1:0] live_q;
    route_t [N_LINKS-1:0] stage_q;
    logic                 rv_q;
    logic [BYTE_W-1:0]    rd_q;
    logic [N_LINKS-1:0]   live_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= '0;
            stage_q <= '0;
            rv_q    <= 1'b0;
            rd_q    <= '0;
        end else begin
            if (rv_q && rsp_ready) begin
                rv_q <= 1'b0;
            end
            if (cmd.vld) begin
                case (cmd.op)
                    OP_ROUTE: begin
                        stage_q[cmd.b] <= '{on: 1'b1, src: cmd.a};
                    end
                    OP_PAIR: begin
                        stage_q[cmd.b] <= '{on: 1'b1, src: cmd.a};
                        stage_q[cmd.a] <= '{on: 1'b1, src: cmd.b};
                    end
                    OP_QUERY: begin
                        rv_q <= 1'b1;
                        rd_q <= pack_resp(live_q[cmd.a]);
                    end
                    OP_COMMIT: begin
                        live_q <= stage_q;
                    end
                    OP_CLEAR: begin
                        live_q  <= '0;
                        stage_q <= '0;
                    end
                    OP_DROP: begin
                        live_q[cmd.a].on  <= 1'b0;
                        stage_q[cmd.a].on <= 1'b0;
                    end
                    default: begin
                        live_q[cmd.a].on  <= 1'b0;
                        stage_q[cmd.a].on <= 1'b0;
                        live_q[cmd.b].on  <= 1'b0;
                        stage_q[cmd.b].on <= 1'b0;
                    end
                endcase
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_LINKS; i++) begin
            live_on[i] = live_q[i].on;
        end
    end

    assign live      = live_q;
    assign rsp_valid = rv_q;
    assign rsp_byte  = rd_q;

    AST_ROUTE_STAGED_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cmd.vld && (cmd.op == OP_ROUTE || cmd.op == OP_PAIR)) |=> $stable(live_q)); // R3

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (rst)
        (cmd.vld && cmd.op == OP_COMMIT) |=> (live_q == $past(stage_q))); // R5

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (cmd.vld && cmd.op == OP_CLEAR) |=> ($countones(live_on) == 0)); // R7

    AST_DROP_NOW: assert property (@(posedge clk) disable iff (rst)
        (cmd.vld && cmd.op == OP_DROP) |=> !live_q[$past(cmd.a)].on); // R8

    AST_QUERY_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (cmd.vld && cmd.op == OP_QUERY) |=> rv_q); // R6

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rv_q && !rsp_ready) |=> (rv_q && $stable(rd_q))); // R12

endmodule

// File: rtl/xbar_out_stage.sv
module xbar_out_stage
    import xbar_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_LINKS-1:0]   link_in,
    input  route_t [N_LINKS-1:0] live,
    output logic [N_LINKS-1:0]   link_out
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][N_LINKS-1:0] sync_q;
    logic [N_LINKS-1:0]                  out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q[0] <= '0;
        end else begin
            sync_q[0] <= link_in;
        end
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[s] <= '0;
            end else begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    for (genvar o = 0; o < N_LINKS; o++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[o] <= 1'b0;
            end else begin
                out_q[o] <= live[o].on & sync_q[LAST][live[o].src];
            end
        end

        AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (rst)
            !live[o].on |=> !out_q[o]); // R10
    end

    assign link_out = out_q;

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
    import xbar_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [BYTE_W-1:0]  cmd_byte,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [BYTE_W-1:0]  rsp_byte,
    input  logic [N_LINKS-1:0] link_in,
    output logic [N_LINKS-1:0] link_out
);

    cmd_t                 cmd;
    route_t [N_LINKS-1:0] live;

    xbar_cmd_parser u_parser (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (cmd_valid),
        .in_byte     (cmd_byte),
        .in_ready    (cmd_ready),
        .rsp_pending (rsp_valid),
        .cmd         (cmd)
    );

    xbar_route_table u_table (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte),
        .live      (live)
    );

    xbar_out_stage #(.SYNC_STAGES(SYNC_STAGES)) u_out (
        .clk      (clk),
        .rst      (rst),
        .link_in  (link_in),
        .live     (live),
        .link_out (link_out)
    );

endmodule

// File: tb/tb_xbar_switch.sv
module tb_xbar_switch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_byte = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [7:0]  rsp_byte;
    logic [31:0] link_in = '0;
    logic [31:0] link_out;

    int checks = 0;
    int fails  = 0;
    bit storm  = 0;
    bit rnd_in = 0;

    always #5 clk = ~clk;

    xbar_switch dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
        .link_in(link_in), .link_out(link_out)
    );

    // behavioural reference model
    int          m_act_on[32], m_act_src[32], m_stg_on[32], m_stg_src[32];
    logic [31:0] m_s1, m_s2, m_out;
    bit          m_rv;
    logic [7:0]  m_rd;
    int          m_st, m_op, m_a;
    bit          m_pv;
    int          m_pop, m_pa, m_pb;
    bit          m_ready;

    function automatic int nargs(int op);
        if (op == 0 || op == 1 || op == 6) return 2;
        if (op == 2 || op == 5) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        logic [31:0] nxt;
        bit acc;
        int b;
        if (rst) begin
            for (int i = 0; i < 32; i++) begin
                m_act_on[i] = 0; m_act_src[i] = 0; m_stg_on[i] = 0; m_stg_src[i] = 0;
            end
            m_s1 = '0; m_s2 = '0; m_out = '0; m_rv = 0; m_rd = '0;
            m_st = 0; m_op = 0; m_a = 0; m_pv = 0; m_pop = 0; m_pa = 0; m_pb = 0;
        end else begin
            acc = cmd_valid && m_ready;
            b   = int'(cmd_byte);
            for (int o = 0; o < 32; o++)
                nxt[o] = (m_act_on[o] != 0) ? m_s2[m_act_src[o]] : 1'b0;
            m_s2 = m_s1;
            m_s1 = link_in;
            if (m_rv && rsp_ready) m_rv = 0;
            if (m_pv) begin
                case (m_pop)
                    0: begin m_stg_on[m_pb] = 1; m_stg_src[m_pb] = m_pa; end
                    1: begin
                        m_stg_on[m_pb] = 1; m_stg_src[m_pb] = m_pa;
                        m_stg_on[m_pa] = 1; m_stg_src[m_pa] = m_pb;
                    end
                    2: begin m_rv = 1; m_rd = {m_act_on[m_pa] != 0, 2'b00, 5'(m_act_src[m_pa])}; end
                    3: for (int i = 0; i < 32; i++) begin
                        m_act_on[i] = m_stg_on[i]; m_act_src[i] = m_stg_src[i];
                    end
                    4: for (int i = 0; i < 32; i++) begin
                        m_act_on[i] = 0; m_act_src[i] = 0; m_stg_on[i] = 0; m_stg_src[i] = 0;
                    end
                    5: begin m_act_on[m_pa] = 0; m_stg_on[m_pa] = 0; end
                    default: begin
                        m_act_on[m_pa] = 0; m_stg_on[m_pa] = 0;
                        m_act_on[m_pb] = 0; m_stg_on[m_pb] = 0;
                    end
                endcase
            end
            m_pv = 0;
            if (acc) begin
                if (m_st == 0) begin
                    if (b < 7) begin
                        m_op = b;
                        if (nargs(b) == 0) begin m_pv = 1; m_pop = b; end
                        else m_st = 1;
                    end
                end else if (m_st == 1) begin
                    if (b >= 32) m_st = 0;
                    else if (nargs(m_op) == 1) begin
                        m_st = 0; m_pv = 1; m_pop = m_op; m_pa = b;
                    end else begin
                        m_a = b; m_st = 2;
                    end
                end else begin
                    m_st = 0;
                    if (b < 32) begin m_pv = 1; m_pop = m_op; m_pa = m_a; m_pb = b; end
                end
            end
            m_out = nxt;
        end
        m_ready = !m_rv && !(m_pv && m_pop == 2);
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check("R2 link_out vs model", link_out, m_out);
            check("R12 cmd_ready vs model", 32'(cmd_ready), 32'(m_ready));
            check("R6 rsp_valid vs model", 32'(rsp_valid), 32'(m_rv));
            if (m_rv) check("R6 rsp_byte vs model", 32'(rsp_byte), 32'(m_rd));
        end
    end

    // input stimulus driver
    always @(negedge clk) begin
        if (rnd_in) link_in <= $urandom;
        if (storm)  rsp_ready <= ($urandom % 3) != 0;
    end

    task automatic send_byte(int v);
        cmd_valid = 1'b1;
        cmd_byte  = 8'(v);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic query(int o, logic [7:0] exp, string tag);
        int guard;
        rsp_ready = 1'b0;
        send_byte(2);
        send_byte(o);
        guard = 0;
        while (!rsp_valid && guard < 20) begin @(negedge clk); guard++; end
        check(tag, 32'(rsp_byte), 32'(exp));
        wait_cyc(3);
        check("R12 response held while stalled", {23'd0, rsp_valid, rsp_byte}, {23'd0, 1'b1, exp});
        check("R12 intake blocked while response pending", 32'(cmd_ready), 32'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs low after reset", link_out, 32'd0);
        check("R1 no response after reset", 32'(rsp_valid), 32'd0);
        check("R1 ready after reset", 32'(cmd_ready), 32'd1);
        query(5, 8'h00, "R1 entry disconnected after reset");

        // staged route is invisible until commit
        link_in = 32'hFFFF_FFFF;
        send_byte(0); send_byte(3); send_byte(7);
        wait_cyc(5);
        check("R3 staged route not yet live", 32'(link_out[7]), 32'd0);
        send_byte(3);
        wait_cyc(2);
        check("R5 commit drives output", 32'(link_out[7]), 32'd1);
        link_in = 32'hFFFF_FFF7;
        wait_cyc(2);
        check("R2 output not yet following", 32'(link_out[7]), 32'd1);
        wait_cyc(1);
        check("R2 output follows input after three edges", 32'(link_out[7]), 32'd0);

        // pair routing
        send_byte(1); send_byte(10); send_byte(20); send_byte(3);
        link_in = 32'h0010_0000;
        wait_cyc(5);
        check("R4 pair route B to A", 32'(link_out[10]), 32'd1);
        check("R4 pair route A to B", 32'(link_out[20]), 32'd0);
        query(10, 8'h94, "R6 enquiry output 10");
        query(20, 8'h8A, "R6 enquiry output 20");
        query(7, 8'h83, "R6 enquiry output 7");

        // single and pair disconnect
        link_in = 32'hFFFF_FFFF;
        send_byte(5); send_byte(7);
        wait_cyc(3);
        check("R8 dropped output low", 32'(link_out[7]), 32'd0);
        query(7, 8'h03, "R8 drop keeps source field");
        send_byte(6); send_byte(10); send_byte(20);
        wait_cyc(3);
        check("R9 pair drop output 10", 32'(link_out[10]), 32'd0);
        check("R9 pair drop output 20", 32'(link_out[20]), 32'd0);
        query(20, 8'h0A, "R9 pair drop enquiry");
        check("R10 disconnected outputs low", link_out, 32'd0);

        // bad opcodes and operands
        send_byte(9); send_byte(8'hFF);
        send_byte(0); send_byte(40);
        send_byte(2); send_byte(33);
        wait_cyc(4);
        check("R11 bad operand gives no response", 32'(rsp_valid), 32'd0);
        check("R11 bad bytes change no output", link_out, 32'd0);
        send_byte(0); send_byte(1); send_byte(2); send_byte(3);
        wait_cyc(5);
        check("R11 parser resynchronised", 32'(link_out[2]), 32'd1);
        query(2, 8'h81, "R11 enquiry after resync");

        // clear all
        send_byte(4);
        wait_cyc(3);
        check("R7 clear forces outputs low", link_out, 32'd0);
        query(2, 8'h00, "R7 clear wipes entry");

        // disconnect before commit
        send_byte(0); send_byte(4); send_byte(5);
        send_byte(5); send_byte(5);
        send_byte(3);
        wait_cyc(5);
        check("R8 staged drop survives commit", 32'(link_out[5]), 32'd0);
        query(5, 8'h04, "R8 staged drop enquiry");

        // random command storm checked by the model
        rnd_in = 1;
        storm  = 1;
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom % 10;
            if (r < 7) send_byte(r);
            else if (r < 9) send_byte($urandom % 34);
            else send_byte($urandom % 256);
        end
        send_byte(3);
        wait_cyc(20);
        storm = 0;
        rsp_ready = 1'b1;
        wait_cyc(4);

        // reset again in the middle of traffic
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs low after second reset", link_out, 32'd0);
        check("R1 no response after second reset", 32'(rsp_valid), 32'd0);
        rnd_in = 0;
        wait_cyc(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule